// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Receiver

This block receives bytes over a two-wire synchronous link made of a serial clock and a data line. Each bit is sampled on a rising clock edge, least significant bit first, and eight bits make a byte. When a byte is complete it moves from the shift register into a receive buffer and a data-ready flag goes high. The host consumes the byte with a one-cycle read strobe.

As clock master, the block makes the serial clock by dividing the system clock by a power of two chosen with a 4-bit rate select. The clock runs without a pause from one byte to the next, so reception is continuous for as long as the host reads each byte in time. If the host falls a byte behind, the overrun flag is set and the older byte is kept. A stop request lets the byte in flight finish and then holds the clock high. As clock slave, the block samples an external clock through a synchronizer and never drives the clock line.

Top module: `csync_rx`

## Requirements
- R1: After reset, rx_data is 0, data_ready and overrun are 0, sclk_out is 1 and sclk_oe is 0.
- R2: While enable and master are both 1, sclk_oe is 1 and sclk_out toggles every 2^(div_sel+1) system clocks, giving a serial clock period of 2^(div_sel+2) system clocks. A clock low phase can only begin while enable and master are both 1.
- R3: Bits are taken on rising serial clock edges and assembled least significant bit first: the first bit received ends up in rx_data[0], the eighth in rx_data[7].
- R4: On the eighth rising edge of a byte, the byte is loaded into rx_data and data_ready is set. As master, this shows two system clocks after sclk_out rises. As slave, it shows five system clocks after sclk_in rises. rx_data changes only when data_ready is set at the same time.
- R5: A one-cycle rd_strobe clears data_ready. If the read lands in the same cycle as a byte completion, the new byte is loaded, data_ready stays 1 and no overrun is recorded. data_ready never falls without a read.
- R6: When the eighth edge of a byte arrives while data_ready is still 1 and no read happens in that cycle, overrun is set, data_ready stays 1 and rx_data keeps the older byte.
- R7: A one-cycle ovr_clr pulse clears overrun. A new overrun in the same cycle wins. overrun falls only after ovr_clr.
- R8: As master, the serial clock period stays constant across byte boundaries. There is no idle gap between consecutive bytes.
- R9: As master, while rx_disable is 1 the byte in progress (any byte whose clock has already gone low) completes. After that, sclk_out stays high and no further rising edge occurs. Clearing rx_disable restarts the clock.
- R10: As slave (enable 1, master 0), sclk_oe is 0 and sclk_out is 1. sclk_in passes through a two-flop synchronizer, and each high and low phase must last at least 3 system clocks. sda_in is carried through the same pipeline, so it only needs to be stable around each rising edge.
- R11: Setting enable to 0 discards a partially received byte, clears the bit counter and returns sclk_out to 1. The next byte after re-enabling is assembled from its own eight bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receiver enable. 0 clears the bit counter and parks the clock |
| master | input | 1 | 1: drive the serial clock. 0: use sclk_in |
| rx_disable | input | 1 | Master only: finish the current byte, then stop the clock |
| div_sel | input | 4 | Master clock rate select, period 2^(div_sel+2) system clocks |
| rd_strobe | input | 1 | One-cycle buffer read, clears data_ready |
| ovr_clr | input | 1 | One-cycle clear of the overrun flag |
| sclk_in | input | 1 | External serial clock in slave mode |
| sda_in | input | 1 | Serial data |
| sclk_out | output | 1 | Serial clock driven in master mode, idle high |
| sclk_oe | output | 1 | Output enable for sclk_out |
| rx_data | output | 8 | Receive buffer |
| data_ready | output | 1 | Buffer holds an unread byte |
| overrun | output | 1 | A byte was lost because the buffer was unread |

## Verification
A bit counter that slips shows up at the buffer on the very next completion, within eight serial clocks: a shifted or rotated byte, or a data_ready edge one serial clock early or late. The bench predicts data_ready, overrun and rx_data every system clock from the edges it observes on the serial clock pins, so any such slip fails in the cycle it first appears. A faulty divider or stop gate shows up on sclk_out within one clock period, and the bench checks this through the rising-edge spacing and through a 300-cycle quiet window after a stop.

// File: rtl/csrx_pkg.sv
package csrx_pkg;
  // one serial-bit sample presented to the shift register
  typedef struct packed {
    logic strobe;  // rising serial clock edge seen this cycle
    logic value;   // data bit belonging to that edge
  } csrx_bit_t;
endpackage

// File: rtl/csrx_clkgen.sv
// Master serial clock: half period of 2^(div_sel+1) system clocks,
// idle high, low phase withheld while halt is asserted.
module csrx_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             halt,
  input  logic [DIV_W-1:0] div_sel,
  output logic             sclk_o,
  output logic             rise_o
);
  localparam int CNT_W = (1 << DIV_W) + 1;
  localparam int SH_W  = DIV_W + 1;

  logic [SH_W-1:0]  sh_amt;
  logic [CNT_W-1:0] half_m1;
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  always_comb begin
    sh_amt  = {1'b0, div_sel} + SH_W'(1);
    half_m1 = (CNT_W'(1) << sh_amt) - CNT_W'(1);
    at_end  = (cnt >= half_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      sclk_o <= 1'b1;
      rise_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      if (sclk_o && halt) begin
        cnt <= '0;
      end else if (at_end) begin
        cnt    <= '0;
        sclk_o <= ~sclk_o;
        rise_o <= ~sclk_o;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/csrx_sync.sv
// Synchronizes an external serial clock and its data, and emits a
// registered one-cycle strobe on each rising clock edge.
module csrx_sync
  import csrx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sclk_i,
  input  logic      sda_i,
  output csrx_bit_t smp_o
);
  logic [STAGES-1:0] c_pipe;
  logic [STAGES-1:0] d_pipe;
  logic              c_last;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          c_pipe <= '1;
          d_pipe <= '0;
        end else begin
          c_pipe <= {c_pipe[STAGES-2:0], sclk_i};
          d_pipe <= {d_pipe[STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          c_pipe <= '1;
          d_pipe <= '0;
        end else begin
          c_pipe <= sclk_i;
          d_pipe <= sda_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      c_last <= 1'b1;
      smp_o  <= '0;
    end else begin
      c_last       <= c_pipe[STAGES-1];
      smp_o.strobe <= c_pipe[STAGES-1] & ~c_last;
      smp_o.value  <= d_pipe[STAGES-1];
    end
  end
endmodule

// File: rtl/csrx_shifter.sv
// LSB-first byte assembly with a bit counter and a completion pulse.
module csrx_shifter
  import csrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  csrx_bit_t         smp,
  output logic              idle_o,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int CW = $clog2(DATA_W);

  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_next;

  assign sh_next = {smp.value, sh[DATA_W-1:1]};
  assign idle_o  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sh     <= '0;
      done_o <= 1'b0;
      byte_o <= '0;
    end else if (clr) begin
      cnt    <= '0;
      sh     <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (smp.strobe) begin
        if (cnt == CW'(DATA_W - 1)) begin
          byte_o <= sh_next;
          done_o <= 1'b1;
          cnt    <= '0;
          sh     <= '0;
        end else begin
          sh  <= sh_next;
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/csrx_bufctl.sv
// Receive buffer with ready and overrun flags.
module csrx_bufctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rd,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              ovr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (ovr_clr) ovr_o <= 1'b0;
      if (done) begin
        if (ready_o && !rd) begin
          ovr_o <= 1'b1;
        end else begin
          data_o  <= byte_i;
          ready_o <= 1'b1;
        end
      end else if (rd) begin
        ready_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csync_rx.sv
module csync_rx
  import csrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              master,
  input  logic              rx_disable,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              rd_strobe,
  input  logic              ovr_clr,
  input  logic              sclk_in,
  input  logic              sda_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_ready,
  output logic              overrun
);
  logic              run;
  logic              halt;
  logic              idle;
  logic              m_rise;
  logic              done;
  logic [DATA_W-1:0] byte_w;
  csrx_bit_t         s_smp;
  csrx_bit_t         smp;

  assign run  = enable & master;
  assign halt = rx_disable & idle;

  always_comb begin
    if (master) begin
      smp.strobe = m_rise;
      smp.value  = sda_in;
    end else begin
      smp = s_smp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sclk_oe <= 1'b0;
    else     sclk_oe <= run;
  end

  csrx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(run), .halt(halt),
    .div_sel(div_sel), .sclk_o(sclk_out), .rise_o(m_rise)
  );

  csrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(sclk_in), .sda_i(sda_in), .smp_o(s_smp)
  );

  csrx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .clr(!enable), .smp(smp),
    .idle_o(idle), .done_o(done), .byte_o(byte_w)
  );

  csrx_bufctl #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .done(done), .byte_i(byte_w),
    .rd(rd_strobe), .ovr_clr(ovr_clr),
    .data_o(rx_data), .ready_o(data_ready), .ovr_o(overrun)
  );
endmodule

// File: rtl/csync_rx_chk.sv
module csync_rx_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              master,
  input logic              rx_disable,
  input logic [DIV_W-1:0]  div_sel,
  input logic              rd_strobe,
  input logic              ovr_clr,
  input logic              sclk_in,
  input logic              sda_in,
  input logic              sclk_out,
  input logic              sclk_oe,
  input logic [DATA_W-1:0] rx_data,
  input logic              data_ready,
  input logic              overrun
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk)
    if (rst_d === 1'b1)
      a_r1_reset_state: assert (!data_ready && !overrun && sclk_out && !sclk_oe);

  a_r2_low_only_as_master: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_out) |-> $past(enable && master));

  a_r4_data_with_ready: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> data_ready);

  a_r5_ready_falls_on_read: assert property (@(posedge clk) disable iff (rst)
    $fell(data_ready) |-> $past(rd_strobe));

  a_r6_keep_old_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> ($stable(rx_data) && data_ready));

  a_r7_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(overrun) |-> $past(ovr_clr));

  a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
    !sclk_oe |-> sclk_out);
endmodule

bind csync_rx csync_rx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_csync_rx.sv
`timescale 1ns/1ps
module sim_csync_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0, master = 1'b0, rx_disable = 1'b0;
  logic [3:0] div_sel = 4'd1;
  logic       rd_strobe = 1'b0, ovr_clr = 1'b0;
  logic       sclk_in = 1'b1, sda_in = 1'b0;
  logic       sclk_out, sclk_oe, data_ready, overrun;
  logic [7:0] rx_data;

  always #5 clk = ~clk;

  csync_rx u0 (
    .clk(clk), .rst(rst), .enable(enable), .master(master),
    .rx_disable(rx_disable), .div_sel(div_sel), .rd_strobe(rd_strobe),
    .ovr_clr(ovr_clr), .sclk_in(sclk_in), .sda_in(sda_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rx_data(rx_data),
    .data_ready(data_ready), .overrun(overrun)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  // reference model state
  int m_data = 0, m_cnt = 0, m_sh = 0;
  bit m_ready = 0, m_ovr = 0;
  int ev_at[$];
  bit ev_bit[$];
  bit txbits[$];
  bit prev_sclk = 1, per_valid = 0, arm = 0;
  int last_rise = 0, rises = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      if (n_err < 40) $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) txbits.push_back(b[i]);
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (rd_strobe) begin m_ready = 0; rd_strobe = 0; end
    if (ovr_clr)   begin m_ovr = 0; ovr_clr = 0; end
    while (ev_at.size() > 0 && ev_at[0] <= cyc) begin
      bit b;
      void'(ev_at.pop_front());
      b = ev_bit.pop_front();
      m_sh = m_sh | (int'(b) << m_cnt);
      m_cnt++;
      if (m_cnt == 8) begin
        if (m_ready) m_ovr = 1;
        else begin m_data = m_sh; m_ready = 1; end
        m_cnt = 0;
        m_sh = 0;
      end
    end
    chk(rx_data === 8'(m_data), "R4 buffer (R3 bit order)", rx_data, m_data);
    chk(data_ready === m_ready, "R5 data_ready", data_ready, m_ready);
    chk(overrun === m_ovr, "R6 overrun", overrun, m_ovr);
    if (!prev_sclk && sclk_out) begin
      ev_at.push_back(cyc + 2);
      ev_bit.push_back(sda_in);
      rises++;
      if (per_valid && !rx_disable)
        chk(cyc - last_rise == (1 << (div_sel + 2)), "R8 clock period",
            cyc - last_rise, 1 << (div_sel + 2));
      per_valid = !rx_disable;
      last_rise = cyc;
    end
    if (prev_sclk && !sclk_out) sda_in = (txbits.size() > 0) ? txbits.pop_front() : 1'b0;
    prev_sclk = sclk_out;
    if (arm && ev_at.size() > 0 && ev_at[0] == cyc + 1 && m_cnt == 7) begin
      rd_strobe = 1;
      arm = 0;
    end
  endtask

  task automatic do_read();
    rd_strobe = 1;
    tick();
  endtask

  task automatic wait_ready(string tag);
    for (int i = 0; i < 3000 && data_ready !== 1'b1; i++) tick();
    chk(data_ready === 1'b1, tag, data_ready, 1);
  endtask

  task automatic slave_bit(bit b, int half);
    sclk_in = 0;
    sda_in = b;
    repeat (half) tick();
    sclk_in = 1;
    ev_at.push_back(cyc + 5);
    ev_bit.push_back(b);
    repeat (half) tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #1500000;
    n_err++;
    $display("FAIL R2 watchdog: actual cycle %0d expected completion", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    tick();
    // R1 reset state
    chk(rx_data === 8'h00 && data_ready === 0 && overrun === 0, "R1 flags/buffer", rx_data, 0);
    chk(sclk_out === 1 && sclk_oe === 0, "R1 clock idle", {sclk_out, sclk_oe}, 2);

    // master, continuous reception
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h81); push_byte(8'h7E);
    push_byte(8'h55); push_byte(8'hE7); push_byte(8'h19);
    div_sel = 4'd1;
    enable = 1; master = 1;
    repeat (2) tick();
    chk(sclk_oe === 1, "R2 output enabled", sclk_oe, 1);
    wait_ready("R4 first byte ready");
    chk(rx_data === 8'hA5, "R3 byte A5", rx_data, 8'hA5);
    do_read();
    wait_ready("R8 second byte ready");
    chk(rx_data === 8'h3C, "R8 back to back byte", rx_data, 8'h3C);
    do_read();
    wait_ready("R4 third byte ready");
    chk(rx_data === 8'h81, "R4 byte 81", rx_data, 8'h81);
    for (int i = 0; i < 3000 && overrun !== 1'b1; i++) tick();
    chk(overrun === 1, "R6 overrun raised", overrun, 1);
    chk(rx_data === 8'h81 && data_ready === 1, "R6 older byte kept", rx_data, 8'h81);
    ovr_clr = 1;
    tick();
    tick();
    chk(overrun === 0, "R7 overrun cleared", overrun, 0);
    do_read();
    wait_ready("R4 fifth byte ready");
    chk(rx_data === 8'h55, "R4 byte 55", rx_data, 8'h55);
    arm = 1;
    for (int i = 0; i < 3000 && arm; i++) tick();
    repeat (3) tick();
    chk(rx_data === 8'hE7 && data_ready === 1, "R5 read coinciding with completion", rx_data, 8'hE7);
    chk(overrun === 0, "R5 no overrun on coincident read", overrun, 0);
    do_read();
    for (int i = 0; i < 3000 && m_cnt != 3; i++) tick();
    rx_disable = 1;
    wait_ready("R9 byte in progress completes");
    chk(rx_data === 8'h19, "R9 last byte 19", rx_data, 8'h19);
    do_read();
    rises = 0;
    repeat (300) tick();
    chk(rises == 0, "R9 no edges after stop", rises, 0);
    chk(sclk_out === 1, "R9 clock parked high", sclk_out, 1);

    // resume at a slower rate
    txbits.delete();
    div_sel = 4'd2;
    push_byte(8'hC3);
    rx_disable = 0;
    wait_ready("R9 resume after stop");
    rx_disable = 1;
    chk(rx_data === 8'hC3, "R2 byte at div 2", rx_data, 8'hC3);
    do_read();
    repeat (40) tick();

    // slave mode
    enable = 0; master = 0;
    repeat (3) tick();
    enable = 1;
    repeat (3) tick();
    chk(sclk_oe === 0 && sclk_out === 1, "R10 clock not driven", {sclk_oe, sclk_out}, 1);
    for (int i = 0; i < 8; i++) slave_bit(((8'h96 >> i) & 1) != 0, 4);
    repeat (8) tick();
    chk(rx_data === 8'h96 && data_ready === 1, "R10 slave byte", rx_data, 8'h96);
    do_read();

    // partial byte discarded by disabling
    slave_bit(1, 3); slave_bit(1, 3); slave_bit(0, 3);
    repeat (8) tick();
    enable = 0;
    m_cnt = 0;
    m_sh = 0;
    repeat (3) tick();
    chk(sclk_out === 1 && data_ready === 0, "R11 idle after disable", sclk_out, 1);
    enable = 1;
    tick();
    for (int i = 0; i < 8; i++) slave_bit(((8'h2B >> i) & 1) != 0, 3);
    repeat (8) tick();
    chk(rx_data === 8'h2B && data_ready === 1, "R11 clean byte after re-enable", rx_data, 8'h2B);
    do_read();
    repeat (5) tick();

    summary();
    $finish;
  end
endmodule